// File: doc/BRIEF.md
# Port, Timer and Interrupt Register Block

This block is a small register file for a peripheral adapter. A host reaches sixteen register slots through a 4-bit select, an 8-bit write bus and separate read and write strobes. There are two 8-bit output ports, each with its own direction register. There are two 16-bit down-counting timers, a mode register and a pair of interrupt registers: one holds the pending flags and one holds the enables. The timers count down only on cycles where the `tick_en` clock enable is high. An active-low interrupt line reports any pending flag whose enable is set.

Timer 1 has a 16-bit reload latch. Writing the high byte of its counter slot copies the whole latch into the counter and arms the timer. In one-shot mode the timer raises its flag once per load. In continuous mode it reloads from the latch on every underflow and raises its flag each time. When the mode register asks for it, port B bit 7 is taken over by a timer-driven waveform: a single pulse in one-shot mode, a square wave in continuous mode. Timer 2 is a one-shot counter loaded through its own low-byte latch.

Each timer runs a small state machine of type `tmr_state_e`, with these states:
- `TS_IDLE`: never loaded since reset.
- `TS_ARMED`: loaded, with a flag still owed.
- `TS_FIRED`: the one-shot flag has been delivered.

It has these transitions:
- LOAD: a counter high-byte write moves any state to `TS_ARMED`.
- EXPIRE: an underflow in `TS_ARMED` in one-shot mode moves to `TS_FIRED`.

Every other case holds the state.

Top module: `pio_timer_irq`

## Requirements
- R1: After reset every register holds zero and `irq_n` is high. The enable register reads 0x80; the flag, mode and port registers read 0x00.
- R2: Slot 0 (port B) and slot 1 (port A) read the output register ANDed with its direction register. Slots 2 and 3 read the direction registers of port B and port A. `pa_drv`/`pa_dir` carry port A's output and direction registers unchanged.
- R3: Writes to slot 4 or slot 6 change only the low byte of the Timer 1 latch. A write to slot 7 sets the latch high byte and clears flag bit 6, but leaves the counter alone. Slots 6 and 7 read back the latch.
- R4: A write to slot 5 sets the latch high byte, loads the counter with {written byte, latch low}, and clears flag bit 6. A load takes priority over a tick in the same cycle.
- R5: Each cycle with `tick_en` high decrements a nonzero counter by one. Slots 4/5 read the Timer 1 counter low/high; slots 8/9 read Timer 2.
- R6: In one-shot mode (mode bit 6 = 0), Timer 1 sets flag bit 6 on the tick that finds the counter at zero, N+1 ticks after loading N. The counter then wraps to 0xFFFF, and later underflows set no flag until the next load.
- R7: In continuous mode (mode bit 6 = 1), each underflow sets flag bit 6 and reloads the counter from the latch, giving a period of N+1 ticks.
- R8: With mode bit 7 = 1, `pb_drv[7]` shows the timer waveform and `pb_dir[7]` is 1. The waveform goes low on a load. It toggles on each continuous-mode underflow, and goes high on the flagged underflow in one-shot mode.
- R9: A write to slot 8 sets the Timer 2 latch low byte. A write to slot 9 loads the Timer 2 counter with {written byte, latch low} and clears flag bit 5. Timer 2 sets flag bit 5 once per load, on its first underflow.
- R10: Slot D reads the flag bits 6:0, with bit 7 as the OR of bits 6:0. Writing slot D clears every flag bit written as 1; a flag set by hardware in the same cycle wins.
- R11: Writing slot E with bit 7 = 1 sets the enable bits written as 1, and with bit 7 = 0 clears them. Bit 7 of slot E always reads 1.
- R12: `irq_n` is low exactly when some flag bit 6:0 and the matching enable bit are both set.
- R13: Slots A, C and F read 0x00, and writes to them change nothing. `rdata` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 4 | Register slot select |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| rd_en | input | 1 | Read strobe; gates `rdata` |
| tick_en | input | 1 | Timer count enable |
| rdata | output | 8 | Read data, combinational from `sel` |
| pa_drv | output | 8 | Port A output register |
| pa_dir | output | 8 | Port A direction register (1 = drive) |
| pb_drv | output | 8 | Port B output, bit 7 optionally the timer waveform |
| pb_dir | output | 8 | Port B direction, bit 7 forced to 1 in waveform mode |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Read data depends only on registers and `sel`, so it is valid in the same cycle as the select. The bench therefore reads one time unit after driving `sel` on a falling edge. Writes, flag changes and waveform changes land on the rising edge that samples the strobe or tick, and `irq_n` follows that edge with no further delay. Each check is therefore taken at the falling edge after the last stimulus edge. For timers, the flag is expected exactly after tick N+1 for a load of N. The bench checks that it is still clear after tick N, so an off-by-one in either direction shows up.

// File: rtl/pio_tmr_pkg.sv
package pio_tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int IRQ_W  = BYTE_W - 1;

    localparam int T1_IRQ_BIT   = 6;
    localparam int T2_IRQ_BIT   = 5;
    localparam int ACR_CONT_BIT = 6;
    localparam int ACR_WAVE_BIT = 7;

    localparam logic [3:0] RS_ORB  = 4'h0;
    localparam logic [3:0] RS_ORA  = 4'h1;
    localparam logic [3:0] RS_DDRB = 4'h2;
    localparam logic [3:0] RS_DDRA = 4'h3;
    localparam logic [3:0] RS_T1CL = 4'h4;
    localparam logic [3:0] RS_T1CH = 4'h5;
    localparam logic [3:0] RS_T1LL = 4'h6;
    localparam logic [3:0] RS_T1LH = 4'h7;
    localparam logic [3:0] RS_T2CL = 4'h8;
    localparam logic [3:0] RS_T2CH = 4'h9;
    localparam logic [3:0] RS_ACR  = 4'hB;
    localparam logic [3:0] RS_IFR  = 4'hD;
    localparam logic [3:0] RS_IER  = 4'hE;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_ARMED = 2'd1,
        TS_FIRED = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/pio_tmr_cnt.sv
module pio_tmr_cnt
    import pio_tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic         cont_mode,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt,
    output logic         evt
);
    tmr_state_e     state_q, state_d;
    logic [W-1:0]   cnt_q;
    logic           uf;

    assign uf  = tick && !load && (cnt_q == '0);
    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE:  if (load) state_d = TS_ARMED;
            TS_ARMED: begin
                if (load)                   state_d = TS_ARMED;
                else if (uf && !cont_mode)  state_d = TS_FIRED;
            end
            TS_FIRED: if (load) state_d = TS_ARMED;
            default:  state_d = TS_IDLE;
        endcase
    end

    always_comb begin
        evt = uf && (cont_mode || (state_q == TS_ARMED));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            if (cnt_q == '0) cnt_q <= cont_mode ? reload_val : '1;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
    import pio_tmr_pkg::*;
#(
    parameter int N = IRQ_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    input  logic         en_wr,
    input  logic [N:0]   en_wdata,
    output logic [N-1:0] flags,
    output logic [N-1:0] enables,
    output logic         irq_n
);
    logic [N-1:0] flag_q, en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            if (en_wdata[N]) en_q <= en_q | en_wdata[N-1:0];
            else             en_q <= en_q & ~en_wdata[N-1:0];
        end
    end

    assign flags   = flag_q;
    assign enables = en_q;
    assign irq_n   = ~|(flag_q & en_q);
endmodule

// File: rtl/pio_timer_irq.sv
module pio_timer_irq
    import pio_tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  sel,
    input  logic [7:0]  wdata,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        tick_en,
    output logic [7:0]  rdata,
    output logic [7:0]  pa_drv,
    output logic [7:0]  pa_dir,
    output logic [7:0]  pb_drv,
    output logic [7:0]  pb_dir,
    output logic        irq_n
);
    logic [BYTE_W-1:0] ora_q, orb_q, ddra_q, ddrb_q, acr_q;
    logic [BYTE_W-1:0] t1_lat_lo, t1_lat_hi, t2_lat_lo;
    logic [CNT_W-1:0]  t1_cnt, t2_cnt, t1_lat;
    logic              t1_evt, t2_evt, wave_q;
    logic [IRQ_W-1:0]  set_mask, clr_mask, ifr, ier;
    logic [BYTE_W-1:0] rd_val;
    logic              w_t1_lo, w_t1_ld, w_t1_hi, w_t2_lo, w_t2_ld, w_ifr, w_ier;

    assign w_t1_lo = wr_en && ((sel == RS_T1CL) || (sel == RS_T1LL));
    assign w_t1_ld = wr_en && (sel == RS_T1CH);
    assign w_t1_hi = wr_en && ((sel == RS_T1CH) || (sel == RS_T1LH));
    assign w_t2_lo = wr_en && (sel == RS_T2CL);
    assign w_t2_ld = wr_en && (sel == RS_T2CH);
    assign w_ifr   = wr_en && (sel == RS_IFR);
    assign w_ier   = wr_en && (sel == RS_IER);
    assign t1_lat  = {t1_lat_hi, t1_lat_lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ora_q <= '0; orb_q <= '0; ddra_q <= '0; ddrb_q <= '0; acr_q <= '0;
            t1_lat_lo <= '0; t1_lat_hi <= '0; t2_lat_lo <= '0;
        end else if (wr_en) begin
            unique case (sel)
                RS_ORB:  orb_q  <= wdata;
                RS_ORA:  ora_q  <= wdata;
                RS_DDRB: ddrb_q <= wdata;
                RS_DDRA: ddra_q <= wdata;
                RS_ACR:  acr_q  <= wdata;
                RS_T2CL: t2_lat_lo <= wdata;
                default: ;
            endcase
            if (w_t1_lo) t1_lat_lo <= wdata;
            if (w_t1_hi) t1_lat_hi <= wdata;
        end
    end

    pio_tmr_cnt #(.W(CNT_W)) u_t1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .load       (w_t1_ld),
        .cont_mode  (acr_q[ACR_CONT_BIT]),
        .load_val   ({wdata, t1_lat_lo}),
        .reload_val (t1_lat),
        .cnt        (t1_cnt),
        .evt        (t1_evt)
    );

    pio_tmr_cnt #(.W(CNT_W)) u_t2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .load       (w_t2_ld),
        .cont_mode  (1'b0),
        .load_val   ({wdata, t2_lat_lo}),
        .reload_val ({CNT_W{1'b0}}),
        .cnt        (t2_cnt),
        .evt        (t2_evt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       wave_q <= 1'b0;
        else if (w_t1_ld) wave_q <= 1'b0;
        else if (t1_evt)  wave_q <= acr_q[ACR_CONT_BIT] ? ~wave_q : 1'b1;
    end

    always_comb begin
        set_mask = '0;
        set_mask[T1_IRQ_BIT] = t1_evt;
        set_mask[T2_IRQ_BIT] = t2_evt;
        clr_mask = w_ifr ? wdata[IRQ_W-1:0] : '0;
        if (w_t1_hi) clr_mask[T1_IRQ_BIT] = 1'b1;
        if (w_t2_ld) clr_mask[T2_IRQ_BIT] = 1'b1;
    end

    pio_irq_ctrl #(.N(IRQ_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .en_wr    (w_ier),
        .en_wdata (wdata),
        .flags    (ifr),
        .enables  (ier),
        .irq_n    (irq_n)
    );

    always_comb begin
        rd_val = '0;
        unique case (sel)
            RS_ORB:  rd_val = orb_q & ddrb_q;
            RS_ORA:  rd_val = ora_q & ddra_q;
            RS_DDRB: rd_val = ddrb_q;
            RS_DDRA: rd_val = ddra_q;
            RS_T1CL: rd_val = t1_cnt[BYTE_W-1:0];
            RS_T1CH: rd_val = t1_cnt[CNT_W-1:BYTE_W];
            RS_T1LL: rd_val = t1_lat_lo;
            RS_T1LH: rd_val = t1_lat_hi;
            RS_T2CL: rd_val = t2_cnt[BYTE_W-1:0];
            RS_T2CH: rd_val = t2_cnt[CNT_W-1:BYTE_W];
            RS_ACR:  rd_val = acr_q;
            RS_IFR:  rd_val = {|ifr, ifr};
            RS_IER:  rd_val = {1'b1, ier};
            default: rd_val = '0;
        endcase
    end

    assign rdata  = rd_en ? rd_val : '0;
    assign pa_drv = ora_q;
    assign pa_dir = ddra_q;
    assign pb_drv = acr_q[ACR_WAVE_BIT] ? {wave_q, orb_q[BYTE_W-2:0]} : orb_q;
    assign pb_dir = acr_q[ACR_WAVE_BIT] ? {1'b1, ddrb_q[BYTE_W-2:0]}  : ddrb_q;
endmodule

// File: rtl/pio_timer_irq_chk.sv
module pio_timer_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  sel,
    input logic [7:0]  wdata,
    input logic        wr_en,
    input logic        rd_en,
    input logic        tick_en,
    input logic [7:0]  rdata,
    input logic        irq_n,
    input logic [15:0] t1_cnt,
    input logic [7:0]  t1_lat_lo,
    input logic        t1_evt,
    input logic        t2_evt,
    input logic [6:0]  ifr
);
    p_load_counter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 4'h5) |=> (t1_cnt == {$past(wdata), $past(t1_lat_lo)}));

    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !(wr_en && sel == 4'h5) && t1_cnt != 16'h0) |=> (t1_cnt == $past(t1_cnt) - 16'h1));

    p_t1_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        t1_evt |=> ifr[6]);

    p_t2_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        t2_evt |=> ifr[5]);

    p_flag_summary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == 4'hD) |-> (rdata[7] == (rdata[6:0] != 7'h0)));

    p_enable_top_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == 4'hE) |-> rdata[7]);

    p_mask_all_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 4'hE && wdata == 8'h7F) |=> irq_n);

    p_unused_slot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == 4'hA || sel == 4'hC || sel == 4'hF)) |-> (rdata == 8'h00));

    p_idle_bus_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == 8'h00));
endmodule

bind pio_timer_irq pio_timer_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .tick_en   (tick_en),
    .rdata     (rdata),
    .irq_n     (irq_n),
    .t1_cnt    (t1_cnt),
    .t1_lat_lo (t1_lat_lo),
    .t1_evt    (t1_evt),
    .t2_evt    (t2_evt),
    .ifr       (ifr)
);

// File: tb/pio_timer_irq_bench.sv
`timescale 1ns/1ps
module pio_timer_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, tick_en = 1'b0;
    logic [7:0] rdata, pa_drv, pa_dir, pb_drv, pb_dir;
    logic       irq_n;
    int         n_tests = 0, n_fail = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    pio_timer_irq u_pio_timer_irq (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .tick_en(tick_en), .rdata(rdata), .pa_drv(pa_drv),
        .pa_dir(pa_dir), .pb_drv(pb_drv), .pb_dir(pb_dir), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        sel = a; rd_en = 1'b1;
        #1 v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, {8'h0, v}, {8'h0, exp});
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, c_lo, c_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 ier", 4'hE, 8'h80);
        rd_chk("R1 ifr", 4'hD, 8'h00);
        rd_chk("R1 acr", 4'hB, 8'h00);
        rd_chk("R1 t1cnt", 4'h4, 8'h00);
        chk("R1 irq_n", {15'h0, irq_n}, 16'h1);
        chk("R1 pa_dir", {8'h0, pa_dir}, 16'h0);

        // R2 port sweep
        for (int d = 0; d < 256; d += 15) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] o;
                o = (k == 0) ? 8'hFF : (k == 1) ? 8'hA5 : 8'h3C;
                wr(4'h1, o); wr(4'h3, d[7:0]);
                wr(4'h0, ~o); wr(4'h2, ~d[7:0]);
                rd_chk("R2 porta", 4'h1, o & d[7:0]);
                rd_chk("R2 portb", 4'h0, ~o & ~d[7:0]);
                rd_chk("R2 ddra", 4'h3, d[7:0]);
                chk("R2 pa_drv", {8'h0, pa_drv}, {8'h0, o});
            end
        end

        // R5 counting
        wr(4'h4, 8'h00); wr(4'h5, 8'h01);
        rd_chk("R4 load hi", 4'h5, 8'h01);
        ticks(1);
        rd_chk("R5 lo", 4'h4, 8'hFF);
        rd_chk("R5 hi", 4'h5, 8'h00);
        ticks(16);
        rd_chk("R5 lo after 17", 4'h4, 8'hEF);

        // R6 one-shot sweep
        for (int n = 0; n < 5; n++) begin
            wr(4'h4, n[7:0]); wr(4'h5, 8'h00);
            rd_chk("R4 flag cleared", 4'hD, 8'h00);
            rd_chk("R4 counter lo", 4'h4, n[7:0]);
            if (n > 0) ticks(n);
            rd_chk("R6 no flag before N+1", 4'hD, 8'h00);
            rd_chk("R6 counter zero", 4'h4, 8'h00);
            ticks(1);
            rd_chk("R6 flag at N+1", 4'hD, 8'hC0);
            rd_chk("R6 wrap lo", 4'h4, 8'hFF);
            rd_chk("R6 wrap hi", 4'h5, 8'hFF);
            wr(4'hD, 8'h40);
            rd_chk("R10 cleared", 4'hD, 8'h00);
        end
        ticks(65536);
        rd_chk("R6 second underflow no flag", 4'hD, 8'h00);
        rd_chk("R6 wrapped again", 4'h5, 8'hFF);

        // R3 latch writes
        rd(4'h4, c_lo); rd(4'h5, c_hi);
        wr(4'hB, 8'h40); ticks(1); wr(4'hB, 8'h00);
        rd(4'h4, c_lo); rd(4'h5, c_hi);
        wr(4'h6, 8'h34); wr(4'h7, 8'h12);
        rd_chk("R3 latch lo", 4'h6, 8'h34);
        rd_chk("R3 latch hi", 4'h7, 8'h12);
        rd_chk("R3 counter lo kept", 4'h4, c_lo);
        rd_chk("R3 counter hi kept", 4'h5, c_hi);
        wr(4'h4, 8'h00); wr(4'h5, 8'h00); ticks(1);
        rd_chk("R3 flag set", 4'hD, 8'hC0);
        wr(4'h7, 8'h00);
        rd_chk("R3 write7 clears flag", 4'hD, 8'h00);

        // R7 / R8 continuous with wave
        wr(4'hB, 8'hC0); wr(4'h6, 8'h03); wr(4'h5, 8'h00);
        chk("R8 wave low after load", {15'h0, pb_drv[7]}, 16'h0);
        chk("R8 dir forced", {15'h0, pb_dir[7]}, 16'h1);
        ticks(3);
        rd_chk("R7 no flag at N", 4'hD, 8'h00);
        ticks(1);
        rd_chk("R7 flag", 4'hD, 8'hC0);
        rd_chk("R7 reload", 4'h4, 8'h03);
        chk("R8 toggle1", {15'h0, pb_drv[7]}, 16'h1);
        // R12 enables
        chk("R12 masked", {15'h0, irq_n}, 16'h1);
        wr(4'hE, 8'hC0);
        chk("R12 asserted", {15'h0, irq_n}, 16'h0);
        wr(4'hD, 8'h40);
        chk("R12 released by clear", {15'h0, irq_n}, 16'h1);
        ticks(4);
        rd_chk("R7 second flag", 4'hD, 8'hC0);
        chk("R8 toggle2", {15'h0, pb_drv[7]}, 16'h0);
        chk("R12 asserted again", {15'h0, irq_n}, 16'h0);
        wr(4'hE, 8'h40);
        chk("R12 disabled", {15'h0, irq_n}, 16'h1);
        rd_chk("R11 cleared", 4'hE, 8'h80);

        // R8 one-shot pulse
        wr(4'hB, 8'h80); wr(4'h6, 8'h02); wr(4'h5, 8'h00);
        chk("R8 pulse low", {15'h0, pb_drv[7]}, 16'h0);
        ticks(3);
        chk("R8 pulse high", {15'h0, pb_drv[7]}, 16'h1);
        ticks(10);
        chk("R8 pulse stays", {15'h0, pb_drv[7]}, 16'h1);
        wr(4'hB, 8'h00);
        wr(4'hD, 8'h7F);

        // R9 timer 2 and R10 combos
        wr(4'h8, 8'h02); wr(4'h9, 8'h00);
        rd_chk("R9 t2 lo", 4'h8, 8'h02);
        ticks(2);
        rd_chk("R9 no flag at N", 4'hD, 8'h00);
        ticks(1);
        rd_chk("R9 flag", 4'hD, 8'hA0);
        rd_chk("R9 wrap", 4'h9, 8'hFF);
        wr(4'h9, 8'h00);
        rd_chk("R9 load clears", 4'hD, 8'h00);
        wr(4'h8, 8'h00); wr(4'h9, 8'h00);
        wr(4'h4, 8'h00); wr(4'h5, 8'h00);
        ticks(1);
        rd_chk("R10 both", 4'hD, 8'hE0);
        wr(4'hD, 8'h20);
        rd_chk("R10 clear t2", 4'hD, 8'hC0);
        wr(4'hD, 8'h40);
        rd_chk("R10 clear t1", 4'hD, 8'h00);
        wr(4'hD, 8'h9F);
        rd_chk("R10 stays clear", 4'hD, 8'h00);

        // R11 enable set/clear
        wr(4'hE, 8'h83);
        rd_chk("R11 set", 4'hE, 8'h83);
        wr(4'hE, 8'h01);
        rd_chk("R11 clear", 4'hE, 8'h82);
        wr(4'hE, 8'hFF);
        rd_chk("R11 all", 4'hE, 8'hFF);
        wr(4'hE, 8'h7F);
        rd_chk("R11 none", 4'hE, 8'h80);

        // R13 unused slots
        wr(4'hB, 8'h21); wr(4'h1, 8'h5A); wr(4'h3, 8'hFF);
        wr(4'hA, 8'h55); wr(4'hC, 8'h55); wr(4'hF, 8'h55);
        rd_chk("R13 slot A", 4'hA, 8'h00);
        rd_chk("R13 slot C", 4'hC, 8'h00);
        rd_chk("R13 slot F", 4'hF, 8'h00);
        rd_chk("R13 acr kept", 4'hB, 8'h21);
        rd_chk("R13 ora kept", 4'h1, 8'h5A);
        rd_chk("R13 ier kept", 4'hE, 8'h80);
        sel = 4'hE; rd_en = 1'b0;
        #1 chk("R13 idle bus", {8'h0, rdata}, 16'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule